// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Phase Check

This block is the byte queue that sits behind a storage controller's data register. The host moves bytes through it one at a time: a write strobe pushes a byte, a read strobe pops one. Reads only take data from the queue when the bus phase code reports a data-in phase. In the data-out phase a read still uses up one unit of occupancy, but it returns zero and leaves the read pointer where it was. The queue refuses to grow past one entry short of its physical depth, and it reports each refused write with a one-cycle overrun pulse.

When a command-collect flag is set, host writes go to a separate command buffer with its own length counter. That buffer reports its own overflow, and it can be read back by index and cleared. A status-load strobe replaces the queue contents with a two-byte response (the status byte, then zero), forces the occupancy to two and sets the transfer-flags output to two. Every successful pop and every status load raises a one-cycle interrupt request pulse. All outputs are registered.

Top module: `pio_byte_fifo`

## Requirements
- R1: After a synchronous reset, fifo_level, cmd_level, host_rdata and xfer_flags are 0, and overrun, cmd_overrun and irq_pulse are low.
- R2: With cmd_collect low, a host write pushes host_wdata and raises fifo_level by one. A read in a data-in phase (bus_phase[2:1] not 00) returns the bytes in write order on host_rdata, one cycle after the strobe.
- R3: A host write while fifo_level is DEPTH-1 (15) is dropped: fifo_level stays unchanged and overrun pulses high for exactly one cycle. fifo_level never exceeds DEPTH-1.
- R4: While cmd_collect is high, a host write stores its byte at index cmd_level of the command buffer and raises cmd_level by one. fifo_level does not change. cmd_rdata shows the entry at cmd_raddr one cycle later.
- R5: A command write while cmd_level equals CMD_DEPTH (16) is dropped, and cmd_overrun pulses for one cycle. cmd_clear sets cmd_level to 0.
- R6: A read with nonzero fifo_level lowers fifo_level by one and pulses irq_pulse for one cycle.
- R7: A read in the data-out phase (bus_phase[2:1] = 00) with nonzero fifo_level returns 0 and does not advance the read pointer. The next data-in read returns the byte that was next in line before it.
- R8: When fifo_level reaches 0, both the read and write pointers return to entry 0. Bytes skipped by data-out reads are therefore never returned later.
- R9: A read at fifo_level 0 changes nothing: host_rdata keeps its last value, irq_pulse stays low and fifo_level stays 0.
- R10: sts_load replaces the queue with sts_byte followed by 0x00, sets fifo_level to 2 and xfer_flags to 2, and pulses irq_pulse.
- R11: xfer_flags returns to 0 when a read brings fifo_level to 0.
- R12: Only one host operation takes effect per cycle. sts_load outranks host_rd, and host_rd outranks host_wr; a strobe that loses is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered read byte |
| bus_phase | input | 3 | Bus phase code; bits 2:1 = 00 means data-out |
| cmd_collect | input | 1 | Send writes to the command buffer |
| sts_load | input | 1 | Load the two-byte status response |
| sts_byte | input | 8 | Status byte for the response |
| cmd_clear | input | 1 | Empty the command buffer |
| cmd_raddr | input | 4 | Command buffer read index |
| cmd_rdata | output | 8 | Registered command buffer entry |
| fifo_level | output | 5 | Queue occupancy |
| cmd_level | output | 5 | Command buffer length |
| xfer_flags | output | 8 | Transfer flags value |
| overrun | output | 1 | One-cycle pulse: queue write refused |
| cmd_overrun | output | 1 | One-cycle pulse: command write refused |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Every result is due exactly one clock edge after the cycle in which its strobe is sampled: host_rdata, fifo_level, cmd_level, xfer_flags, cmd_rdata and all three pulses are registered straight from the decision made in that cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. Each check therefore sees the response to exactly one operation. For the pulse outputs, a second sample one idle cycle later confirms that the pulse lasts a single cycle.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STATUS = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } host_op_e;

  localparam logic [7:0] FLAGS_AFTER_STATUS = 8'd2;
  localparam logic [7:0] STATUS_TAIL_BYTE   = 8'h00;

  // Data-out is signalled by phase bits 2:1 both zero.
  function automatic logic phase_is_out(input logic [2:0] ph);
    return (ph[2:1] == 2'b00);
  endfunction

endpackage

// File: rtl/pio_fifo_regfile.sv
module pio_fifo_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [WIDTH-1:0] data_a,
  input  logic             we_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [WIDTH-1:0] data_b,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [DEPTH*WIDTH-1:0] flat;

  // One register per entry so two entries can be written in the same cycle.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (we_a && addr_a == AW'(i)) begin
        q <= data_a;
      end else if (we_b && addr_b == AW'(i)) begin
        q <= data_b;
      end
    end
    assign flat[i*WIDTH +: WIDTH] = q;
  end

  assign rdata = flat[raddr*WIDTH +: WIDTH];

endmodule

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  input  logic [2:0]    bus_phase,
  input  logic          cmd_collect,
  input  logic          sts_load,
  input  logic [7:0]    sts_byte,
  // storage interface
  output logic          st_we_a,
  output logic [AW-1:0] st_addr_a,
  output logic [7:0]    st_data_a,
  output logic          st_we_b,
  output logic [AW-1:0] st_addr_b,
  output logic [7:0]    st_data_b,
  output logic [AW-1:0] st_raddr,
  input  logic [7:0]    st_rdata,
  // command buffer push
  output logic          cmd_push,
  // registered results
  output logic [7:0]    host_rdata,
  output logic [LW-1:0] fifo_level,
  output logic [7:0]    xfer_flags,
  output logic          overrun,
  output logic          irq_pulse
);

  localparam logic [LW-1:0] FULL_MARK = LW'(DEPTH - 1);

  host_op_e      op;
  logic [AW-1:0] rptr_q, wptr_q;
  logic [LW-1:0] occ_q;
  logic          fifo_push, push_reject, pop, read_out;

  always_comb begin
    if (sts_load)     op = OP_STATUS;
    else if (host_rd) op = OP_READ;
    else if (host_wr) op = OP_WRITE;
    else              op = OP_IDLE;
  end

  assign fifo_push   = (op == OP_WRITE) && !cmd_collect && (occ_q != FULL_MARK);
  assign push_reject = (op == OP_WRITE) && !cmd_collect && (occ_q == FULL_MARK);
  assign cmd_push    = (op == OP_WRITE) && cmd_collect;
  assign pop         = (op == OP_READ) && (occ_q != '0);
  assign read_out    = phase_is_out(bus_phase);

  // Port A carries normal pushes and the status byte; port B the zero tail.
  assign st_we_a   = fifo_push || (op == OP_STATUS);
  assign st_addr_a = (op == OP_STATUS) ? '0 : wptr_q;
  assign st_data_a = (op == OP_STATUS) ? sts_byte : host_wdata;
  assign st_we_b   = (op == OP_STATUS);
  assign st_addr_b = AW'(1);
  assign st_data_b = STATUS_TAIL_BYTE;
  assign st_raddr  = rptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q     <= '0;
      wptr_q     <= '0;
      occ_q      <= '0;
      host_rdata <= '0;
      xfer_flags <= '0;
      overrun    <= 1'b0;
      irq_pulse  <= 1'b0;
    end else begin
      overrun   <= push_reject;
      irq_pulse <= pop || (op == OP_STATUS);
      unique case (op)
        OP_STATUS: begin
          occ_q      <= LW'(2);
          rptr_q     <= '0;
          wptr_q     <= AW'(2);
          xfer_flags <= FLAGS_AFTER_STATUS;
        end
        OP_READ: begin
          if (pop) begin
            occ_q <= occ_q - 1'b1;
            if (read_out) begin
              host_rdata <= 8'h00;
            end else begin
              host_rdata <= st_rdata;
              rptr_q     <= rptr_q + 1'b1;
            end
            if (occ_q == LW'(1)) begin
              rptr_q     <= '0;
              wptr_q     <= '0;
              xfer_flags <= '0;
            end
          end
        end
        OP_WRITE: begin
          if (fifo_push) begin
            wptr_q <= wptr_q + 1'b1;
            occ_q  <= occ_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign fifo_level = occ_q;

endmodule

// File: rtl/pio_cmd_buf.sv
module pio_cmd_buf #(
  parameter int CMD_DEPTH = 16,
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [7:0]     wdata,
  input  logic           clear,
  input  logic [CAW-1:0] rd_addr,
  output logic [7:0]     rd_data,
  output logic [CLW-1:0] level,
  output logic           ovf
);

  logic [CLW-1:0] len_q;
  logic           full, we;
  logic [7:0]     raw;

  assign full = (len_q == CLW'(CMD_DEPTH));
  assign we   = push && !clear && !full;

  pio_fifo_regfile #(.DEPTH(CMD_DEPTH), .WIDTH(8)) u_store (
    .clk    (clk),
    .we_a   (we),
    .addr_a (len_q[CAW-1:0]),
    .data_a (wdata),
    .we_b   (1'b0),
    .addr_b ('0),
    .data_b (8'h00),
    .raddr  (rd_addr),
    .rdata  (raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      ovf     <= 1'b0;
      rd_data <= '0;
    end else begin
      ovf     <= push && !clear && full;
      rd_data <= raw;
      if (clear)   len_q <= '0;
      else if (we) len_q <= len_q + 1'b1;
    end
  end

  assign level = len_q;

endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 16,
  localparam int LW  = $clog2(DEPTH + 1),
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_wr,
  input  logic [7:0]     host_wdata,
  input  logic           host_rd,
  output logic [7:0]     host_rdata,
  input  logic [2:0]     bus_phase,
  input  logic           cmd_collect,
  input  logic           sts_load,
  input  logic [7:0]     sts_byte,
  input  logic           cmd_clear,
  input  logic [CAW-1:0] cmd_raddr,
  output logic [7:0]     cmd_rdata,
  output logic [LW-1:0]  fifo_level,
  output logic [CLW-1:0] cmd_level,
  output logic [7:0]     xfer_flags,
  output logic           overrun,
  output logic           cmd_overrun,
  output logic           irq_pulse
);

  localparam int AW = $clog2(DEPTH);

  logic          st_we_a, st_we_b, cmd_push;
  logic [AW-1:0] st_addr_a, st_addr_b, st_raddr;
  logic [7:0]    st_data_a, st_data_b, st_rdata;

  pio_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rd     (host_rd),
    .bus_phase   (bus_phase),
    .cmd_collect (cmd_collect),
    .sts_load    (sts_load),
    .sts_byte    (sts_byte),
    .st_we_a     (st_we_a),
    .st_addr_a   (st_addr_a),
    .st_data_a   (st_data_a),
    .st_we_b     (st_we_b),
    .st_addr_b   (st_addr_b),
    .st_data_b   (st_data_b),
    .st_raddr    (st_raddr),
    .st_rdata    (st_rdata),
    .cmd_push    (cmd_push),
    .host_rdata  (host_rdata),
    .fifo_level  (fifo_level),
    .xfer_flags  (xfer_flags),
    .overrun     (overrun),
    .irq_pulse   (irq_pulse)
  );

  pio_fifo_regfile #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
    .clk    (clk),
    .we_a   (st_we_a),
    .addr_a (st_addr_a),
    .data_a (st_data_a),
    .we_b   (st_we_b),
    .addr_b (st_addr_b),
    .data_b (st_data_b),
    .raddr  (st_raddr),
    .rdata  (st_rdata)
  );

  pio_cmd_buf #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .push    (cmd_push),
    .wdata   (host_wdata),
    .clear   (cmd_clear),
    .rd_addr (cmd_raddr),
    .rd_data (cmd_rdata),
    .level   (cmd_level),
    .ovf     (cmd_overrun)
  );

endmodule

// File: rtl/pio_byte_fifo_chk.sv
module pio_byte_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 16,
  localparam int LW  = $clog2(DEPTH + 1),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           host_wr,
  input logic           host_rd,
  input logic [7:0]     host_rdata,
  input logic           cmd_collect,
  input logic           sts_load,
  input logic [LW-1:0]  fifo_level,
  input logic [CLW-1:0] cmd_level,
  input logic [7:0]     xfer_flags,
  input logic           overrun,
  input logic           irq_pulse
);

  // R3: a write at the full mark is refused and flagged
  a_r3_refuse_at_mark: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_rd && !sts_load && !cmd_collect && fifo_level == LW'(DEPTH - 1))
      |=> (overrun && fifo_level == LW'(DEPTH - 1)));

  // R3: occupancy stays below the physical depth
  a_r3_level_cap: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH - 1));

  // R6: a pop lowers occupancy by one and requests an interrupt
  a_r6_pop_irq: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !sts_load && fifo_level != '0)
      |=> (irq_pulse && (fifo_level + 1'b1) == $past(fifo_level)));

  // R9: a read of an empty queue has no effect
  a_r9_empty_read: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !sts_load && fifo_level == '0)
      |=> (!irq_pulse && $stable(host_rdata) && fifo_level == '0));

  // R10: status load sets level, flags and interrupt
  a_r10_status_load: assert property (@(posedge clk) disable iff (rst)
    sts_load |=> (fifo_level == LW'(2) && xfer_flags == 8'd2 && irq_pulse));

  // R4: command bytes never enter the queue
  a_r4_cmd_bypass: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_rd && !sts_load && cmd_collect) |=> $stable(fifo_level));

  // R5: command length stays within the command buffer
  a_r5_cmd_cap: assert property (@(posedge clk) disable iff (rst)
    cmd_level <= CLW'(CMD_DEPTH));

endmodule

bind pio_byte_fifo pio_byte_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_rdata  (host_rdata),
  .cmd_collect (cmd_collect),
  .sts_load    (sts_load),
  .fifo_level  (fifo_level),
  .cmd_level   (cmd_level),
  .xfer_flags  (xfer_flags),
  .overrun     (overrun),
  .irq_pulse   (irq_pulse)
);

// File: tb/pio_byte_fifo_bench.sv
module pio_byte_fifo_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, cmd_collect = 1'b0;
  logic       sts_load = 1'b0, cmd_clear = 1'b0;
  logic [7:0] host_wdata = '0, sts_byte = '0;
  logic [2:0] bus_phase = 3'b010;
  logic [3:0] cmd_raddr = '0;
  logic [7:0] host_rdata, cmd_rdata, xfer_flags;
  logic [4:0] fifo_level, cmd_level;
  logic       overrun, cmd_overrun, irq_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  localparam logic [2:0] PH_IN  = 3'b011;
  localparam logic [2:0] PH_OUT = 3'b001;

  always #2 clk = ~clk;

  pio_byte_fifo u_pio_byte_fifo (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .bus_phase(bus_phase),
    .cmd_collect(cmd_collect), .sts_load(sts_load), .sts_byte(sts_byte),
    .cmd_clear(cmd_clear), .cmd_raddr(cmd_raddr), .cmd_rdata(cmd_rdata),
    .fifo_level(fifo_level), .cmd_level(cmd_level), .xfer_flags(xfer_flags),
    .overrun(overrun), .cmd_overrun(cmd_overrun), .irq_pulse(irq_pulse)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All operations start and end on a falling edge.
  task automatic op(input bit wr, input logic [7:0] wd, input bit rd,
                    input bit sl, input logic [7:0] sb);
    host_wr = wr; host_wdata = wd; host_rd = rd; sts_load = sl; sts_byte = sb;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; sts_load = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d); op(1'b1, d, 1'b0, 1'b0, 8'h00); endtask
  task automatic rd_byte();                    op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00); endtask
  task automatic idle();                       op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle();

    // R1 reset state
    chk(fifo_level == 0, "R1 level", fifo_level, 0);
    chk(cmd_level == 0, "R1 cmd_level", cmd_level, 0);
    chk(host_rdata == 0, "R1 rdata", host_rdata, 0);
    chk(xfer_flags == 0, "R1 flags", xfer_flags, 0);
    chk(!overrun && !cmd_overrun && !irq_pulse, "R1 pulses", irq_pulse, 0);

    // R9 read of empty queue
    bus_phase = PH_IN;
    rd_byte();
    chk(fifo_level == 0 && host_rdata == 0, "R9 level", fifo_level, 0);
    chk(!irq_pulse, "R9 irq", irq_pulse, 0);

    // R2/R6 sweep: fill k bytes, drain them, for every k
    for (int k = 1; k <= 15; k++) begin
      for (int i = 0; i < k; i++) begin
        wr_byte(pat(i + k));
        chk(fifo_level == 5'(i + 1), "R2 fill level", fifo_level, i + 1);
      end
      for (int i = 0; i < k; i++) begin
        rd_byte();
        chk(host_rdata == pat(i + k), "R2 order", host_rdata, pat(i + k));
        chk(fifo_level == 5'(k - 1 - i), "R6 drain level", fifo_level, k - 1 - i);
        chk(irq_pulse, "R6 irq", irq_pulse, 1);
      end
    end

    // R3 overrun at level 15
    for (int i = 0; i < 15; i++) wr_byte(pat(i));
    wr_byte(8'hEE);
    chk(overrun, "R3 overrun pulse", overrun, 1);
    chk(fifo_level == 15, "R3 level held", fifo_level, 15);
    idle();
    chk(!overrun, "R3 pulse width", overrun, 0);
    for (int i = 0; i < 15; i++) rd_byte();
    chk(host_rdata == pat(14), "R3 byte dropped", host_rdata, pat(14));
    rd_byte();
    chk(host_rdata == pat(14) && fifo_level == 0, "R3 no extra byte", host_rdata, pat(14));

    // R7 data-out read returns zero and keeps the pointer
    wr_byte(8'h5A); wr_byte(8'hC3);
    bus_phase = PH_OUT;
    rd_byte();
    chk(host_rdata == 0, "R7 zero data", host_rdata, 0);
    chk(fifo_level == 1 && irq_pulse, "R7 level", fifo_level, 1);
    bus_phase = PH_IN;
    rd_byte();
    chk(host_rdata == 8'h5A, "R7 pointer kept", host_rdata, 8'h5A);

    // R8 rewind on empty
    wr_byte(8'h11); wr_byte(8'h22);
    bus_phase = PH_OUT;
    rd_byte(); rd_byte();
    chk(fifo_level == 0, "R8 emptied", fifo_level, 0);
    bus_phase = PH_IN;
    wr_byte(8'h77);
    rd_byte();
    chk(host_rdata == 8'h77, "R8 rewind", host_rdata, 8'h77);

    // R10 status load over existing data, R11 flags clear
    wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03);
    op(1'b0, 8'h00, 1'b0, 1'b1, 8'hA5);
    chk(fifo_level == 2, "R10 level", fifo_level, 2);
    chk(xfer_flags == 2, "R10 flags", xfer_flags, 2);
    chk(irq_pulse, "R10 irq", irq_pulse, 1);
    rd_byte();
    chk(host_rdata == 8'hA5, "R10 status byte", host_rdata, 8'hA5);
    chk(xfer_flags == 2, "R11 flags kept", xfer_flags, 2);
    rd_byte();
    chk(host_rdata == 8'h00, "R10 tail byte", host_rdata, 0);
    chk(xfer_flags == 0 && fifo_level == 0, "R11 flags cleared", xfer_flags, 0);

    // R12 priority
    op(1'b1, 8'h99, 1'b1, 1'b1, 8'h3C);
    chk(fifo_level == 2, "R12 status wins", fifo_level, 2);
    rd_byte();
    chk(host_rdata == 8'h3C, "R12 status data", host_rdata, 8'h3C);
    op(1'b1, 8'h99, 1'b1, 1'b0, 8'h00);
    chk(fifo_level == 0 && host_rdata == 8'h00, "R12 read wins", fifo_level, 0);
    rd_byte();
    chk(fifo_level == 0 && !irq_pulse, "R12 write ignored", fifo_level, 0);

    // R4 command collection, R5 command overflow and clear
    wr_byte(8'h44);
    cmd_collect = 1'b1;
    for (int i = 0; i < 16; i++) begin
      wr_byte(pat(i + 100));
      chk(cmd_level == 5'(i + 1), "R4 cmd level", cmd_level, i + 1);
      chk(fifo_level == 1, "R4 fifo untouched", fifo_level, 1);
    end
    wr_byte(8'hF0);
    chk(cmd_overrun && cmd_level == 16, "R5 cmd overflow", cmd_level, 16);
    idle();
    chk(!cmd_overrun, "R5 pulse width", cmd_overrun, 0);
    for (int i = 0; i < 16; i++) begin
      cmd_raddr = 4'(i);
      idle();
      chk(cmd_rdata == pat(i + 100), "R4 cmd data", cmd_rdata, pat(i + 100));
    end
    cmd_clear = 1'b1;
    idle();
    cmd_clear = 1'b0;
    chk(cmd_level == 0, "R5 clear", cmd_level, 0);
    cmd_collect = 1'b0;
    rd_byte();
    chk(host_rdata == 8'h44 && fifo_level == 0, "R4 queue intact", host_rdata, 8'h44);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule